// File: doc/BRIEF.md
# SPI Port-Expander Register Slave

This block is an SPI slave that models one 8-bit general-purpose I/O expander port. A host frames each transaction with an active-low select. The first byte is a control byte: its upper seven bits must match the device opcode, and its lowest bit chooses between read and write. The second byte is a register address. Every byte after that is data for the addressed register, and the address steps forward after each data byte. Bits are shifted most significant first. The slave samples on the rising serial-clock edge and changes its data-out line on the falling edge.

A direction register selects input or output for each pin. It resets to all inputs. An output latch holds the drive value, and a pin is driven only where its direction bit is 0. The SPI pins are oversampled by the block clock through synchronisers, so the serial clock must stay well below the block clock. Dropping the select line part-way through a byte throws that byte away.

Register map: 0x00 direction (1 = input), 0x09 port (a write sets the latch, a read returns the pin levels), 0x0A latch (read and write). Every other address reads 0 and ignores writes.

Top module: `spi_port_expander`

## Requirements
- R1: After reset the direction register is 0xFF and the latch is 0x00, so `pin_oe` and `pin_out` are both 0x00.
- R2: A frame 0x40, 0x00, D writes D to the direction register (MSB first). After that, `pin_oe` equals the bitwise inverse of D.
- R3: A write to address 0x09 sets the latch. `pin_out` always equals latch AND `pin_oe`.
- R4: A control byte whose upper seven bits are not 0100000 makes the rest of the frame have no effect on any register.
- R5: A control byte 0x41 (bit 0 = 1 means read) returns register contents on `spi_miso`, MSB first, changing after falling serial-clock edges. Address 0x00 returns the direction register, 0x09 returns `pin_in`, 0x0A returns the latch, and any other address returns 0x00.
- R6: Each further data byte in a frame goes to the next address. After 0x0A the address wraps to 0x00, for reads and for writes.
- R7: If the select line rises before all eight bits of a data byte have arrived, that partial byte changes no register.
- R8: A write to 0x0A sets the latch. A write to any address outside 0x00, 0x09 and 0x0A changes nothing.
- R9: `spi_miso` is 0 whenever the select line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| pin_in | input | 8 | Levels sensed on the port pins |
| pin_out | output | 8 | Drive values for the port pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = driven |

## Verification
The bench builds the block with its default parameters: opcode 0100000, two synchroniser stages, and the top address 0x0A. With the top address that low, the address wrap from 0x0A to 0x00 can be reached inside one short burst, in both read and write frames. The bench holds each serial-clock half period for eight block clocks, so the synchroniser and edge-detect latency settles before each comparison. That lets the behavioural model be compared at every half-bit point, including the point where a select pulse truncates a byte part-way through.

// File: rtl/spi_pe_pkg.sv
// Shared definitions for the SPI port-expander slave.
// Assumes byte-wide frames; the phase type is used by the frame engine.
package spi_pe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } frame_phase_t;
endpackage

// File: rtl/spi_pe_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous input pins.
// Assumes the inputs change much more slowly than clk. RST_VAL sets the
// value the chain holds while in reset.
module spi_pe_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move each sample one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pe_frame.sv
// SPI frame engine: it decodes the control, address and data bytes of a frame.
// Assumes synchronised inputs and SPI mode 0: sample on the rising edge, shift
// on the falling edge. It emits a one-cycle write strobe for each complete
// data byte of a write frame, and loads read data at byte boundaries.
module spi_pe_frame
    import spi_pe_pkg::*;
#(
    parameter logic [6:0] OPCODE    = 7'b0100000,
    parameter logic [7:0] LAST_ADDR = 8'h0A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                cs_n_s,
    input  logic                mosi_s,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic [BYTE_W-1:0]   rd_addr_o,
    output logic                wr_en_o,
    output logic [BYTE_W-1:0]   wr_addr_o,
    output logic [BYTE_W-1:0]   wr_data_o,
    output logic                miso_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    frame_phase_t       phase_q;
    logic               sclk_d_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  rx_q;
    logic [BYTE_W-1:0]  tx_q;
    logic [BYTE_W-1:0]  addr_q;
    logic               rd_q;
    logic               rise, fall;
    logic [BYTE_W-1:0]  byte_in;
    logic [BYTE_W-1:0]  addr_next;

    assign rise      = sclk_s & ~sclk_d_q & ~cs_n_s;
    assign fall      = ~sclk_s & sclk_d_q & ~cs_n_s;
    assign byte_in   = {rx_q[BYTE_W-2:0], mosi_s};
    assign addr_next = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

    // Purpose: keep the previous serial-clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d_q <= 1'b0;
        else        sclk_d_q <= sclk_s;
    end

    // Purpose: bit counting, byte decoding and phase sequencing on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CTRL;
            cnt_q   <= '0;
            rx_q    <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            wr_en_o <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (cs_n_s) begin
                phase_q <= PH_CTRL;
                cnt_q   <= '0;
            end else if (rise) begin
                rx_q  <= byte_in;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(BYTE_W-1)) begin
                    unique case (phase_q)
                        PH_CTRL: begin
                            rd_q    <= byte_in[0];
                            phase_q <= (byte_in[7:1] == OPCODE) ? PH_ADDR : PH_SKIP;
                        end
                        PH_ADDR: begin
                            addr_q  <= byte_in;
                            phase_q <= PH_DATA;
                        end
                        PH_DATA: begin
                            wr_en_o   <= ~rd_q;
                            wr_addr_o <= addr_q;
                            wr_data_o <= byte_in;
                            addr_q    <= addr_next;
                        end
                        default: phase_q <= PH_SKIP;
                    endcase
                end
            end
        end
    end

    // Purpose: load or shift the read shifter on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            tx_q <= '0;
        end else if (fall) begin
            if (phase_q == PH_DATA && rd_q && cnt_q == '0) tx_q <= rd_data_i;
            else                                           tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign rd_addr_o = addr_q;
    assign miso_o    = tx_q[BYTE_W-1] & ~cs_n_s;

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !wr_en_o);  // R7
    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP) |-> !wr_en_o);  // R4
    AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (cnt_q == '0));  // R7
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_s) && cs_n_s |-> !miso_o);  // R9
endmodule

// File: rtl/spi_pe_regs.sv
// Port register file: the direction register, the output latch and the read
// multiplexer. Assumes the write strobe lasts one cycle. Pins drive only where
// the direction bit is 0.
module spi_pe_regs
    import spi_pe_pkg::*;
#(
    parameter logic [7:0] DIR_ADDR = 8'h00,
    parameter logic [7:0] PIN_ADDR = 8'h09,
    parameter logic [7:0] LAT_ADDR = 8'h0A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [BYTE_W-1:0]  wr_addr_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    input  logic [BYTE_W-1:0]  rd_addr_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    input  logic [BYTE_W-1:0]  pin_in_i,
    output logic [BYTE_W-1:0]  pin_out_o,
    output logic [BYTE_W-1:0]  pin_oe_o
);
    logic [BYTE_W-1:0] dir_q;
    logic [BYTE_W-1:0] lat_q;

    // Purpose: update the direction register and the latch from write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == DIR_ADDR) dir_q <= wr_data_i;
            if (wr_addr_i == PIN_ADDR || wr_addr_i == LAT_ADDR) lat_q <= wr_data_i;
        end
    end

    // Purpose: select the value returned for a read address.
    always_comb begin
        if      (rd_addr_i == DIR_ADDR) rd_data_o = dir_q;
        else if (rd_addr_i == PIN_ADDR) rd_data_o = pin_in_i;
        else if (rd_addr_i == LAT_ADDR) rd_data_o = lat_q;
        else                            rd_data_o = '0;
    end

    assign pin_oe_o  = ~dir_q;
    assign pin_out_o = lat_q & ~dir_q;

    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(dir_q));  // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(lat_q));  // R3
    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != DIR_ADDR && wr_addr_i != PIN_ADDR && wr_addr_i != LAT_ADDR)
        |=> ($stable(dir_q) && $stable(lat_q)));  // R8
endmodule

// File: rtl/spi_port_expander.sv
// Top of the SPI port-expander slave. It synchronises the SPI pins, decodes
// frames and holds the port registers. Assumes the serial clock is slower than
// clk/8 so that the synchroniser and edge-detect latency settle between edges.
module spi_port_expander #(
    parameter logic [6:0] OPCODE      = 7'b0100000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DIR_ADDR    = 8'h00,
    parameter logic [7:0] PIN_ADDR    = 8'h09,
    parameter logic [7:0] LAT_ADDR    = 8'h0A,
    parameter logic [7:0] LAST_ADDR   = 8'h0A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe
);
    logic [2:0] pins_s;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    spi_pe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({spi_sclk, spi_cs_n, spi_mosi}),
        .sync_o(pins_s)
    );

    spi_pe_frame #(.OPCODE(OPCODE), .LAST_ADDR(LAST_ADDR)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .miso_o(spi_miso)
    );

    spi_pe_regs #(.DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR), .LAT_ADDR(LAT_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );
endmodule

// File: tb/test_spi_port_expander.sv
// Bench for spi_port_expander: a behavioural model of the register state,
// compared at every serial half-bit settle point.
module test_spi_port_expander;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] pin_in = 8'h3C;
    logic [7:0] pin_out, pin_oe;

    int checks = 0, errors = 0;
    int cycles = 0;

    // model state
    logic [7:0] m_dir = 8'hFF, m_lat = 8'h00;

    always #2 clk = ~clk;

    spi_port_expander i_spi_port_expander (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return m_dir;
        if (a == 8'h09) return pin_in;
        if (a == 8'h0A) return m_lat;
        return 8'h00;
    endfunction

    task automatic check_ports(input string req);
        check8({req, " pin_oe"}, pin_oe, ~m_dir);
        check8({req, " pin_out"}, pin_out, m_lat & ~m_dir);
    endtask

    // Send one frame; the last byte is cut to last_bits bits when last_bits > 0.
    task automatic xfer(input string req, input logic [7:0] b[$], input int last_bits);
        int phase = 0;
        logic [7:0] addr = 0;
        logic rd = 0;
        logic [7:0] exp_rd = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < b.size(); i++) begin
            int nb = (i == b.size()-1 && last_bits > 0) ? last_bits : 8;
            if (phase == 2 && rd) exp_rd = m_read(addr);
            for (int k = 0; k < nb; k++) begin
                mosi = b[i][7-k];
                wait_clk(HALF);
                if (phase == 2 && rd) begin
                    checks++;
                    if (miso !== exp_rd[7-k]) begin
                        errors++;
                        $display("FAIL %s miso bit%0d actual=%0b expected=%0b", req, 7-k, miso, exp_rd[7-k]);
                    end
                end
                sclk = 1'b1;
                if (k == 7) begin
                    case (phase)
                        0: begin rd = b[i][0]; phase = (b[i][7:1] == 7'b0100000) ? 1 : 3; end
                        1: begin addr = b[i]; phase = 2; end
                        2: begin
                            if (!rd) begin
                                if (addr == 8'h00) m_dir = b[i];
                                if (addr == 8'h09 || addr == 8'h0A) m_lat = b[i];
                            end
                            addr = (addr == 8'h0A) ? 8'h00 : addr + 8'h01;
                        end
                        default: ;
                    endcase
                end
                wait_clk(HALF);
                check_ports(req);
                sclk = 1'b0;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
        check_ports(req);
        check8({req, " R9 miso idle"}, {7'b0, miso}, 8'h00);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        check8("R1 pin_oe", pin_oe, 8'h00);
        check8("R1 pin_out", pin_out, 8'h00);
        check8("R9 miso idle", {7'b0, miso}, 8'h00);
        // R2 direction all outputs
        xfer("R2 dir", '{8'h40, 8'h00, 8'h00}, 0);
        // R3 port write drives pins
        xfer("R3 port", '{8'h40, 8'h09, 8'hA5}, 0);
        // R2/R3 partial direction masks the drive
        xfer("R2 dir mask", '{8'h40, 8'h00, 8'h0F}, 0);
        // R4 opcode mismatch ignored
        xfer("R4 bad opcode", '{8'h50, 8'h00, 8'hFF}, 0);
        xfer("R4 bad opcode hi", '{8'hC0, 8'h09, 8'h12}, 0);
        xfer("R4 near opcode", '{8'h42, 8'h00, 8'hAA}, 0);
        // R5 reads
        xfer("R5 read dir", '{8'h41, 8'h00, 8'h00}, 0);
        xfer("R5 read pins", '{8'h41, 8'h09, 8'hFF}, 0);
        xfer("R5 read latch", '{8'h41, 8'h0A, 8'h00}, 0);
        xfer("R5 read unmapped", '{8'h41, 8'h05, 8'h00}, 0);
        // R6 sequential write and wrap
        xfer("R6 seq write", '{8'h40, 8'h09, 8'h11, 8'h22}, 0);
        pin_in = 8'hC3;
        xfer("R6 seq read wrap", '{8'h41, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00}, 0);
        xfer("R6 write wrap", '{8'h40, 8'h0A, 8'h33, 8'hF0}, 0);
        xfer("R6 readback", '{8'h41, 8'h0A, 8'h00, 8'h00}, 0);
        // R7 partial data byte discarded
        xfer("R7 partial", '{8'h40, 8'h09, 8'hFF}, 5);
        xfer("R7 partial dir", '{8'h40, 8'h00, 8'h00}, 7);
        xfer("R7 readback", '{8'h41, 8'h0A, 8'h00}, 0);
        // R8 latch alias and unmapped write
        xfer("R8 latch write", '{8'h40, 8'h0A, 8'h5A}, 0);
        xfer("R8 unmapped write", '{8'h40, 8'h03, 8'h77}, 0);
        xfer("R8 unmapped read", '{8'h41, 8'h03, 8'h00, 8'h00}, 0);
        xfer("R2 all out", '{8'h40, 8'h00, 8'h00}, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule